// File: doc/BRIEF.md
# Boot Role Controller

This block sits in every logical core and decides, once per reset, whether the core becomes the bootstrap core or an application core. When reset ends it checks whether the core has been fused off. If not, it starts the core's self-test and waits for the result. A core that passes then sends a single election request, tagged with a priority derived from its own ID, to a shared hub. The hub picks one request and sends the winning ID back to every core, including the core that sent it.

The core compares the broadcast ID with its own. On a match it raises its bootstrap flag and enables instruction fetch from the firmware entry point. On a mismatch it clears the flag and parks until a startup interrupt arrives. The interrupt then enables fetch as an application core. A core that fails self-test sends no request and parks in the same way. A fused-off core stays inert.

The request leaves on a valid/ready channel. Once `req_valid` rises, it and `req_prio` stay steady for as long as `req_ready` is low. The transfer completes on the first clock edge where both are high, and `req_valid` falls in the next cycle. The hub can stall the request indefinitely. The core never withdraws the request and never sends it twice. The broadcast and the startup interrupt are plain single-cycle inputs with no back-pressure.

Top module: `boot_role_ctrl`

## Requirements
- R1: While `rst_n` is low, `bist_start`, `req_valid`, `bsp_flag` and `fetch_en` are all 0.
- R2: If `fused_off` is 1 in the first cycle after reset release, the core never raises `bist_start`, `req_valid`, `bsp_flag` or `fetch_en`, and `sipi` has no effect.
- R3: On a core that is not fused off, `bist_start` is 1 from the first cycle after reset release up to and including the cycle in which `bist_done` is sampled high.
- R4: If `bist_done` and `bist_pass` are both 1 while `bist_start` is 1, then `req_valid` is 1 in the next cycle. `req_prio` equals `core_id` when `PRIO_INVERT`=0, and equals the bitwise inverse of `core_id` when `PRIO_INVERT`=1.
- R5: While `req_valid` is 1 and `req_ready` is 0, `req_valid` and `req_prio` hold. After the edge where both are 1, `req_valid` is 0 and never rises again before the next reset.
- R6: If `bist_done` is 1 and `bist_pass` is 0, the core sends no request and parks with `bsp_flag`=0 and `fetch_en`=0. A later `sipi` pulse sets `fetch_en` to 1.
- R7: A `bcast_valid` pulse that arrives before the request handshake has completed is ignored, whatever its ID.
- R8: After the handshake, a broadcast whose `bcast_id` equals `core_id` sets `bsp_flag` and `fetch_en` to 1 in the next cycle. Both then stay 1 until reset.
- R9: After the handshake, a broadcast whose ID differs from `core_id` leaves `bsp_flag`=0 and `fetch_en`=0. A later `sipi` pulse sets `fetch_en` to 1 while `bsp_flag` stays 0, and both then stay in that state.
- R10: `sipi` is ignored in every state except the parked application wait, including while waiting for the broadcast and after winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_id | input | ID_W | Unique ID of this logical core |
| fused_off | input | 1 | Core marked non-working; keeps it out of the election |
| bist_start | output | 1 | Self-test run request, level |
| bist_done | input | 1 | Self-test finished, one-cycle pulse |
| bist_pass | input | 1 | Self-test result, valid with bist_done |
| req_valid | output | 1 | Election request valid |
| req_ready | input | 1 | Hub accepts the election request |
| req_prio | output | ID_W | Arbitration priority carried by the request |
| bcast_valid | input | 1 | Winner broadcast valid, one-cycle pulse |
| bcast_id | input | ID_W | ID of the elected core |
| sipi | input | 1 | Startup interrupt pulse |
| bsp_flag | output | 1 | This core is the bootstrap core |
| fetch_en | output | 1 | Instruction fetch enabled |

## Verification
The bench sends a matching broadcast while the request is still stalled. A design that listened too early would elect itself without ever being accepted by the hub. It holds `req_ready` low across several cycles, which catches a request that drops or changes its priority under back-pressure. It pulses the startup interrupt while the core is waiting for the broadcast, after it has won, and on a fused-off core, to catch a design that lets the interrupt wake a core in the wrong state. It also checks the self-test failure path and the mismatch path, so that a controller that requests anyway after a failure, or that sets the flag on any broadcast, is reported.

// File: rtl/boot_role_pkg.sv
package boot_role_pkg;

  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_SELFTEST = 3'd1,
    ST_REQUEST  = 3'd2,
    ST_AWAIT    = 3'd3,
    ST_BSP_RUN  = 3'd4,
    ST_AP_WAIT  = 3'd5,
    ST_AP_RUN   = 3'd6,
    ST_DISABLED = 3'd7
  } role_state_t;

endpackage

// File: rtl/brc_prio_map.sv
module brc_prio_map #(
  parameter int ID_W        = 8,
  parameter bit PRIO_INVERT = 1'b0
) (
  input  logic [ID_W-1:0] id_i,
  output logic [ID_W-1:0] prio_o
);

  generate
    if (PRIO_INVERT) begin : g_inv
      assign prio_o = ~id_i;
    end else begin : g_ident
      assign prio_o = id_i;
    end
  endgenerate

endmodule

// File: rtl/brc_req_chan.sv
module brc_req_chan #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch_i,
  input  logic [ID_W-1:0] prio_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [ID_W-1:0] prio_o,
  output logic            fire_o
);

  logic            vld_q;
  logic [ID_W-1:0] prio_q;

  assign fire_o  = vld_q && ready_i;
  assign valid_o = vld_q;
  assign prio_o  = prio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      prio_q <= '0;
    end else if (launch_i && !vld_q) begin
      vld_q  <= 1'b1;
      prio_q <= prio_i;
    end else if (fire_o) begin
      vld_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/brc_id_match.sv
module brc_id_match #(
  parameter int ID_W = 8
) (
  input  logic            arm_i,
  input  logic            bvalid_i,
  input  logic [ID_W-1:0] bid_i,
  input  logic [ID_W-1:0] own_i,
  output logic            win_o,
  output logic            lose_o
);

  logic seen;
  logic same;

  assign seen   = arm_i && bvalid_i;
  assign same   = (bid_i == own_i);
  assign win_o  = seen && same;
  assign lose_o = seen && !same;

endmodule

// File: rtl/boot_role_ctrl.sv
module boot_role_ctrl
  import boot_role_pkg::*;
#(
  parameter int ID_W        = 8,
  parameter bit PRIO_INVERT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] core_id,
  input  logic            fused_off,
  output logic            bist_start,
  input  logic            bist_done,
  input  logic            bist_pass,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [ID_W-1:0] req_prio,
  input  logic            bcast_valid,
  input  logic [ID_W-1:0] bcast_id,
  input  logic            sipi,
  output logic            bsp_flag,
  output logic            fetch_en
);

  role_state_t     st_q, st_d;
  logic [ID_W-1:0] prio_w;
  logic            launch;
  logic            fire;
  logic            win;
  logic            lose;
  logic            bsp_q, fetch_q;

  brc_prio_map #(.ID_W(ID_W), .PRIO_INVERT(PRIO_INVERT)) u_prio (
    .id_i   (core_id),
    .prio_o (prio_w)
  );

  assign launch = (st_q == ST_SELFTEST) && bist_done && bist_pass;

  brc_req_chan #(.ID_W(ID_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .prio_i   (prio_w),
    .ready_i  (req_ready),
    .valid_o  (req_valid),
    .prio_o   (req_prio),
    .fire_o   (fire)
  );

  brc_id_match #(.ID_W(ID_W)) u_match (
    .arm_i    (st_q == ST_AWAIT),
    .bvalid_i (bcast_valid),
    .bid_i    (bcast_id),
    .own_i    (core_id),
    .win_o    (win),
    .lose_o   (lose)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RESET:    st_d = fused_off ? ST_DISABLED : ST_SELFTEST;
      ST_SELFTEST: if (bist_done) st_d = bist_pass ? ST_REQUEST : ST_AP_WAIT;
      ST_REQUEST:  if (fire) st_d = ST_AWAIT;
      ST_AWAIT: begin
        if (win)       st_d = ST_BSP_RUN;
        else if (lose) st_d = ST_AP_WAIT;
      end
      ST_AP_WAIT:  if (sipi) st_d = ST_AP_RUN;
      ST_BSP_RUN, ST_AP_RUN, ST_DISABLED: st_d = st_q;
      default:     st_d = ST_DISABLED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_RESET;
      bsp_q   <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      bsp_q   <= (st_d == ST_BSP_RUN);
      fetch_q <= (st_d == ST_BSP_RUN) || (st_d == ST_AP_RUN);
    end
  end

  assign bist_start = (st_q == ST_SELFTEST);
  assign bsp_flag   = bsp_q;
  assign fetch_en   = fetch_q;

endmodule

// File: rtl/boot_role_chk.sv
module boot_role_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bist_start,
  input logic            bist_done,
  input logic            bist_pass,
  input logic            req_valid,
  input logic            req_ready,
  input logic [ID_W-1:0] req_prio,
  input logic            bsp_flag,
  input logic            fetch_en
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !rst_n || (!req_valid && !bsp_flag && !fetch_en));

  // R3
  no_req_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |-> !req_valid);

  // R4
  pass_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start && bist_done && bist_pass |=> req_valid);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_prio));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  // R6
  fail_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start && bist_done && !bist_pass |=> !req_valid);

  // R8
  bsp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsp_flag |=> bsp_flag && fetch_en);

  // R9
  ap_run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en && !bsp_flag |=> fetch_en && !bsp_flag);

endmodule

bind boot_role_ctrl boot_role_chk #(.ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bist_start (bist_start),
  .bist_done  (bist_done),
  .bist_pass  (bist_pass),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_prio   (req_prio),
  .bsp_flag   (bsp_flag),
  .fetch_en   (fetch_en)
);

// File: tb/sim_boot_role_ctrl.sv
module sim_boot_role_ctrl;
  localparam int ID_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [ID_W-1:0] core_id;
  logic            fused_off;
  logic            bist_start, bist_done, bist_pass;
  logic            req_valid, req_ready;
  logic [ID_W-1:0] req_prio;
  logic            bcast_valid;
  logic [ID_W-1:0] bcast_id;
  logic            sipi;
  logic            bsp_flag, fetch_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  boot_role_ctrl #(.ID_W(ID_W), .PRIO_INVERT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .core_id(core_id), .fused_off(fused_off),
    .bist_start(bist_start), .bist_done(bist_done), .bist_pass(bist_pass),
    .req_valid(req_valid), .req_ready(req_ready), .req_prio(req_prio),
    .bcast_valid(bcast_valid), .bcast_id(bcast_id), .sipi(sipi),
    .bsp_flag(bsp_flag), .fetch_en(fetch_en)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic [3:0] exp);
    chk(req, {28'd0, bist_start, req_valid, bsp_flag, fetch_en}, {28'd0, exp});
  endtask

  task automatic do_reset(input logic [ID_W-1:0] id, input logic fz);
    rst_n = 1'b0; core_id = id; fused_off = fz;
    bist_done = 0; bist_pass = 0; req_ready = 0;
    bcast_valid = 0; bcast_id = '0; sipi = 0;
    tick(); tick();
    outs("R1 reset", 4'b0000);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_sipi();
    sipi = 1'b1; tick(); sipi = 1'b0;
  endtask

  task automatic pulse_bcast(input logic [ID_W-1:0] id);
    bcast_valid = 1'b1; bcast_id = id; tick(); bcast_valid = 1'b0;
  endtask

  task automatic finish_test(input logic pass);
    outs("R3 test running", 4'b1000);
    tick();
    outs("R3 test held", 4'b1000);
    bist_done = 1'b1; bist_pass = pass; tick();
    bist_done = 1'b0; bist_pass = 1'b0;
  endtask

  task automatic t_fused();
    do_reset(8'h11, 1'b1);
    outs("R2 fused idle", 4'b0000);
    bist_done = 1'b1; bist_pass = 1'b1; tick();
    bist_done = 1'b0; bist_pass = 1'b0;
    pulse_sipi();
    tick();
    outs("R2 fused after sipi", 4'b0000);
  endtask

  task automatic t_win();
    do_reset(8'h05, 1'b0);
    finish_test(1'b1);
    outs("R4 request up", 4'b0100);
    chk("R4 prio", {24'd0, req_prio}, 32'h05);
    pulse_bcast(8'h05);
    outs("R7 early bcast ignored", 4'b0100);
    tick(); tick();
    outs("R5 held under stall", 4'b0100);
    chk("R5 prio held", {24'd0, req_prio}, 32'h05);
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    outs("R5 drop after accept", 4'b0000);
    pulse_sipi();
    outs("R10 sipi in await", 4'b0000);
    pulse_bcast(8'h05);
    outs("R8 won", 4'b0011);
    pulse_sipi();
    tick();
    outs("R10 sipi after win", 4'b0011);
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    outs("R5 no second request", 4'b0011);
  endtask

  task automatic t_lose();
    do_reset(8'h03, 1'b0);
    finish_test(1'b1);
    chk("R4 prio lose", {24'd0, req_prio}, 32'h03);
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    pulse_bcast(8'h06);
    outs("R9 lost parked", 4'b0000);
    tick(); tick();
    outs("R9 still parked", 4'b0000);
    pulse_sipi();
    outs("R9 ap run", 4'b0001);
    pulse_bcast(8'h03);
    outs("R9 ap run sticky", 4'b0001);
  endtask

  task automatic t_fail();
    do_reset(8'h07, 1'b0);
    finish_test(1'b0);
    outs("R6 no request", 4'b0000);
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    pulse_bcast(8'h07);
    outs("R6 bcast ignored", 4'b0000);
    pulse_sipi();
    outs("R6 sipi wakes", 4'b0001);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_fused();
    t_win();
    t_lose();
    t_fail();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule